// File: doc/BRIEF.md
# Speculative Load Address Guard Table

This block keeps track of loads that a scheduler has hoisted above earlier stores. When such a load issues it writes its destination register number together with the doubleword it read into a small associative table. Every store then searches all entries at once and knocks out any whose doubleword it touches. Later, at the load's original position, a check names the destination register. The table answers either "still valid", so the speculative value may be kept, or "recover", so the pipeline branches to fix-up code.

A check asks for recovery in three cases: a store overlapped the load's doubleword, the entry was pushed out by a newer load, or the entry was never written. Entries are keyed by register number, so a second speculative load to the same register takes over the first one's slot. A clear input empties the whole table, for example on a context switch.

Top module: `ldspec_table`

## Requirements
- R1: After reset every entry is invalid, the rotation pointer is 0, and `rsp_valid`, `rsp_hit` and `rsp_recover` are low. A check made right after reset asks for recovery.
- R2: A check is answered on the clock edge that samples it: `rsp_valid` is high in the following cycle, with `rsp_hit`=1 and `rsp_recover`=0 when a valid entry holds the checked register.
- R3: A check of a register that has no valid entry answers `rsp_hit`=0 and `rsp_recover`=1.
- R4: Addresses are compared on bits [ADDR_W-1:3]. A store to any byte of the 8-byte doubleword recorded for an entry invalidates that entry. A store to a neighbouring doubleword leaves it valid.
- R5: One store invalidates every valid entry whose doubleword matches, in the same cycle.
- R6: An insert to a register that already has a valid entry overwrites that entry's address. No second entry is created, and the old address no longer invalidates it.
- R7: An insert first uses the lowest-numbered invalid slot. When all slots are valid and the register is absent, the insert evicts the slot named by a rotation pointer. The pointer then advances by one and wraps after ENTRIES-1. An evicted register's later check asks for recovery.
- R8: A check that hits does not change the entry, so a repeated check hits again.
- R9: `clr` invalidates all entries and resets the rotation pointer to 0. An insert in the same cycle as `clr` is discarded.
- R10: When an insert and a store occur in the same cycle, the inserted entry is treated as younger and stays valid, even if its doubleword matches. Older matching entries are still invalidated.
- R11: A check sees the table as it was before the same cycle's insert, store and clear.
- R12: `rsp_hit` and `rsp_recover` are never high together. `rsp_valid` is high exactly in the cycle after each check request, and exactly one of the two answers is high with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Invalidate all entries and reset the rotation pointer |
| ld_valid | input | 1 | Speculative load insert request |
| ld_reg | input | REG_W | Destination register of the speculative load |
| ld_addr | input | ADDR_W | Byte address read by the speculative load |
| st_valid | input | 1 | Store probe request |
| st_addr | input | ADDR_W | Byte address written by the store |
| chk_valid | input | 1 | Check request |
| chk_reg | input | REG_W | Register whose entry is checked |
| rsp_valid | output | 1 | Check response valid, one cycle after the request |
| rsp_hit | output | 1 | Entry present and valid; the speculative value may be used |
| rsp_recover | output | 1 | Entry absent or invalidated; branch to recovery |

## Verification
The functions that share a cycle are the load insert and the store probe. The bench drives both in one cycle with the same doubleword. The inserted register must then check as a hit, while an older entry in that doubleword must check as recovery (R10). Collisions between a check and an insert or store in the same cycle are also provoked. Those checks are judged against the table state before the cycle (R11), and a follow-up check confirms the state after it. The same goes for clear and insert in one cycle (R9).

// File: rtl/ldspec_pkg.sv
package ldspec_pkg;

  // Address bits below this position select a byte inside a doubleword.
  localparam int unsigned DWORD_SHIFT = 3;

  // Doubleword number of a byte address (addresses up to 64 bits).
  function automatic logic [63:0] dword_index(input logic [63:0] byte_addr);
    return byte_addr >> DWORD_SHIFT;
  endfunction

  // Next rotation position with wrap at the slot count.
  function automatic int unsigned rotate_next(input int unsigned cur,
                                              input int unsigned slots);
    return (cur + 1 >= slots) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/ldspec_entry.sv
module ldspec_entry #(
  parameter int unsigned REG_W = 7,
  parameter int unsigned TAG_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_reg,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             snoop_en,
  input  logic [TAG_W-1:0] snoop_tag,
  output logic             valid_o,
  output logic [REG_W-1:0] reg_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             snoop_hit_o
);

  logic             valid_q;
  logic [REG_W-1:0] reg_q;
  logic [TAG_W-1:0] tag_q;

  // Store probe hits this slot when the slot is live and the doubleword matches.
  assign snoop_hit_o = valid_q && snoop_en && (tag_q == snoop_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      reg_q   <= '0;
      tag_q   <= '0;
    end else if (clr) begin
      valid_q <= 1'b0;
    end else if (wr_en) begin
      // The insert is younger than a same-cycle store, so it wins.
      valid_q <= 1'b1;
      reg_q   <= wr_reg;
      tag_q   <= wr_tag;
    end else if (snoop_hit_o) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign reg_o   = reg_q;
  assign tag_o   = tag_q;

  // R4: a store that hits a slot not being rewritten leaves it invalid.
  a_r4_snoop_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit_o && !wr_en && !clr) |=> !valid_o);

  // R10: a slot written without clear is valid next cycle whatever the store does.
  a_r10_insert_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> valid_o);

endmodule

// File: rtl/ldspec_alloc.sv
module ldspec_alloc #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned REG_W   = 7,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          ld_valid,
  input  logic [REG_W-1:0]              ld_reg,
  input  logic [ENTRIES-1:0]            valid_vec,
  input  logic [ENTRIES-1:0][REG_W-1:0] reg_vec,
  output logic [ENTRIES-1:0]            wr_vec,
  output logic                          evict_o
);
  import ldspec_pkg::*;

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] match_idx, free_idx, pick_idx;
  logic             match_any, free_any;
  logic [ENTRIES-1:0] reg_hit;

  // Slot selection: same register first, then lowest free, then rotation.
  always_comb begin
    match_any = 1'b0;
    free_any  = 1'b0;
    match_idx = '0;
    free_idx  = '0;
    for (int i = 0; i < int'(ENTRIES); i++) begin
      reg_hit[i] = valid_vec[i] && (reg_vec[i] == ld_reg);
    end
    for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
      if (reg_hit[i]) begin
        match_any = 1'b1;
        match_idx = IDX_W'(i);
      end
      if (!valid_vec[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    if (match_any)     pick_idx = match_idx;
    else if (free_any) pick_idx = free_idx;
    else               pick_idx = rr_ptr;
  end

  assign evict_o = ld_valid && !clr && !match_any && !free_any;
  assign wr_vec  = (ld_valid && !clr) ? (ENTRIES'(1) << pick_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (clr) begin
      rr_ptr <= '0;
    end else if (evict_o) begin
      rr_ptr <= IDX_W'(rotate_next(int'(rr_ptr), ENTRIES));
    end
  end

  // R6: an insert writes at most one slot.
  a_r6_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

  // R7: eviction only happens with every slot in use.
  a_r7_evict_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    evict_o |-> (valid_vec == {ENTRIES{1'b1}}));

  // R7: the rotation pointer moves after each eviction.
  a_r7_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_o && ENTRIES > 1) |=> (rr_ptr != $past(rr_ptr)));

endmodule

// File: rtl/ldspec_lookup.sv
module ldspec_lookup #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned REG_W   = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          chk_valid,
  input  logic [REG_W-1:0]              chk_reg,
  input  logic [ENTRIES-1:0]            valid_vec,
  input  logic [ENTRIES-1:0][REG_W-1:0] reg_vec,
  output logic                          rsp_valid,
  output logic                          rsp_hit,
  output logic                          rsp_recover
);

  logic [ENTRIES-1:0] probe_hit;
  logic               found;

  always_comb begin
    for (int i = 0; i < int'(ENTRIES); i++) begin
      probe_hit[i] = valid_vec[i] && (reg_vec[i] == chk_reg);
    end
  end

  assign found = |probe_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_recover <= 1'b0;
    end else begin
      rsp_valid   <= chk_valid;
      rsp_hit     <= chk_valid && found;
      rsp_recover <= chk_valid && !found;
    end
  end

  // R12: the two answers exclude each other.
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_recover));

  // R12: a request is answered in the next cycle.
  a_r12_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> rsp_valid);

  // R12: a valid response carries exactly one answer.
  a_r12_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_recover));

  // R6: at most one valid slot holds a given register.
  a_r6_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_hit));

endmodule

// File: rtl/ldspec_table.sv
module ldspec_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned REG_W   = 7,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ld_valid,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_recover
);
  import ldspec_pkg::*;

  localparam int unsigned TAG_W = ADDR_W - DWORD_SHIFT;

  logic [TAG_W-1:0]              ld_tag, st_tag;
  logic [ENTRIES-1:0]            valid_vec, wr_vec, snoop_vec;
  logic [ENTRIES-1:0][REG_W-1:0] reg_vec;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_vec;
  logic                          evict;

  assign ld_tag = TAG_W'(dword_index(64'(ld_addr)));
  assign st_tag = TAG_W'(dword_index(64'(st_addr)));

  ldspec_alloc #(.ENTRIES(ENTRIES), .REG_W(REG_W)) alloc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .ld_valid  (ld_valid),
    .ld_reg    (ld_reg),
    .valid_vec (valid_vec),
    .reg_vec   (reg_vec),
    .wr_vec    (wr_vec),
    .evict_o   (evict)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    ldspec_entry #(.REG_W(REG_W), .TAG_W(TAG_W)) entry_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .wr_en       (wr_vec[g]),
      .wr_reg      (ld_reg),
      .wr_tag      (ld_tag),
      .snoop_en    (st_valid),
      .snoop_tag   (st_tag),
      .valid_o     (valid_vec[g]),
      .reg_o       (reg_vec[g]),
      .tag_o       (tag_vec[g]),
      .snoop_hit_o (snoop_vec[g])
    );
  end

  ldspec_lookup #(.ENTRIES(ENTRIES), .REG_W(REG_W)) lookup_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_valid   (chk_valid),
    .chk_reg     (chk_reg),
    .valid_vec   (valid_vec),
    .reg_vec     (reg_vec),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_recover (rsp_recover)
  );

  // R9: clear empties the table by the next cycle.
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid_vec == '0));

  // R5: a store never leaves a live slot that holds its doubleword unless rewritten.
  a_r5_all_matches_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !clr) |=> ($countones(valid_vec & ~$past(wr_vec) & $past(snoop_vec)) == 0));

  // R7: an eviction keeps the number of live slots at the maximum.
  a_r7_evict_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (evict && !st_valid) |=> ($countones(valid_vec) == ENTRIES));

  // R1: nothing is live while reset is held.
  always_comb begin
    if (!rst_n) a_r1_reset_empty: assert (valid_vec == '0);
  end

endmodule

// File: tb/ldspec_table_tb.sv
module ldspec_table_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_ENT  = 4;
  localparam int RW     = 4;
  localparam int AW     = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          ld_valid = 1'b0;
  logic [RW-1:0] ld_reg = '0;
  logic [AW-1:0] ld_addr = '0;
  logic          st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic          chk_valid = 1'b0;
  logic [RW-1:0] chk_reg = '0;
  logic          rsp_valid, rsp_hit, rsp_recover;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldspec_table #(.ENTRIES(N_ENT), .REG_W(RW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_reg(chk_reg),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_recover(rsp_recover)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // One clock cycle with the given inputs; returns at the following falling edge.
  task automatic cyc(input logic lv, input int lr, input int la,
                     input logic sv, input int sa,
                     input logic cv, input int cr, input logic c);
    ld_valid = lv; ld_reg = RW'(lr); ld_addr = AW'(la);
    st_valid = sv; st_addr = AW'(sa);
    chk_valid = cv; chk_reg = RW'(cr); clr = c;
    @(negedge clk);
    ld_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0; clr = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic exp_hit);
    check_bit({req, " rsp_valid"}, rsp_valid, 1'b1);
    check_bit({req, " rsp_hit"}, rsp_hit, exp_hit);
    check_bit({req, " rsp_recover"}, rsp_recover, !exp_hit);
  endtask

  task automatic ins(input int r, input int a);  cyc(1, r, a, 0, 0, 0, 0, 0); endtask
  task automatic st(input int a);                cyc(0, 0, 0, 1, a, 0, 0, 0); endtask
  task automatic wipe();                         cyc(0, 0, 0, 0, 0, 0, 0, 1); endtask
  task automatic chk(input string req, input int r, input logic exp_hit);
    cyc(0, 0, 0, 0, 0, 1, r, 0);
    expect_rsp(req, exp_hit);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: outputs low in reset
    check_bit("R1 rsp_valid", rsp_valid, 1'b0);
    check_bit("R1 rsp_hit", rsp_hit, 1'b0);
    check_bit("R1 rsp_recover", rsp_recover, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R3: empty table, every register asks for recovery
    for (int r = 0; r < (1 << RW); r++) chk("R1 R3 empty", r, 1'b0);

    // R2/R3: fill four registers, sweep all register numbers
    for (int r = 0; r < N_ENT; r++) ins(r, 16'h0100 + 16 * r);
    for (int r = 0; r < (1 << RW); r++) chk(r < N_ENT ? "R2 present" : "R3 absent", r, r < N_ENT);
    // R12: idle cycle gives no response
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    check_bit("R12 idle rsp_valid", rsp_valid, 1'b0);
    // R8: repeated hits
    chk("R8 first", 0, 1'b1);
    chk("R8 again", 0, 1'b1);

    // R9: clear empties everything
    wipe();
    for (int r = 0; r < N_ENT; r++) chk("R9 cleared", r, 1'b0);

    // R4: every byte of the doubleword kills, neighbours do not
    for (int off = 0; off < 8; off++) begin
      ins(5, 16'h0203);
      st(16'h0208 + off);
      chk("R4 next dword", 5, 1'b1);
      st(16'h01F8 + off);
      chk("R4 prev dword", 5, 1'b1);
      st(16'h0200 + off);
      chk("R4 same dword", 5, 1'b0);
    end

    // R5: one store kills all matching entries
    wipe();
    ins(1, 16'h0300); ins(2, 16'h0304); ins(3, 16'h0310);
    st(16'h0307);
    chk("R5 first match", 1, 1'b0);
    chk("R5 second match", 2, 1'b0);
    chk("R5 other dword", 3, 1'b1);

    // R6: same register replaces its entry
    wipe();
    ins(7, 16'h0400); ins(7, 16'h0500);
    st(16'h0400);
    chk("R6 old address ignored", 7, 1'b1);
    st(16'h0500);
    chk("R6 new address kills, no duplicate", 7, 1'b0);

    // R7: lowest free fill, then rotation eviction
    wipe();
    for (int r = 0; r < N_ENT; r++) ins(r, 16'h0800 + 8 * r);
    ins(8, 16'h0900);
    chk("R7 evict slot0", 0, 1'b0);
    for (int r = 1; r < N_ENT; r++) chk("R7 kept", r, 1'b1);
    chk("R7 newcomer", 8, 1'b1);
    ins(9, 16'h0908);
    chk("R7 evict slot1", 1, 1'b0);
    chk("R7 keep 2", 2, 1'b1);
    chk("R7 keep 8", 8, 1'b1);
    ins(10, 16'h0910); ins(11, 16'h0918);
    chk("R7 evict slot2", 2, 1'b0);
    chk("R7 evict slot3", 3, 1'b0);
    ins(12, 16'h0920);
    chk("R7 pointer wrapped", 8, 1'b0);
    chk("R7 keep 9", 9, 1'b1);

    // R9: clear beats a same-cycle insert
    wipe();
    cyc(1, 6, 16'h0600, 0, 0, 0, 0, 1);
    chk("R9 insert dropped", 6, 1'b0);

    // R10: insert younger than same-cycle store
    ins(4, 16'h0604);
    cyc(1, 6, 16'h0600, 1, 16'h0602, 0, 0, 0);
    chk("R10 insert survives", 6, 1'b1);
    chk("R10 older killed", 4, 1'b0);

    // R11: check sees state before the cycle's updates
    cyc(1, 11, 16'h0700, 0, 0, 1, 11, 0);
    expect_rsp("R11 before insert", 1'b0);
    chk("R11 after insert", 11, 1'b1);
    cyc(0, 0, 0, 1, 16'h0705, 1, 11, 0);
    expect_rsp("R11 before store", 1'b1);
    chk("R11 after store", 11, 1'b0);
    ins(11, 16'h0700);
    cyc(0, 0, 0, 0, 0, 1, 11, 1);
    expect_rsp("R11 before clear", 1'b1);
    chk("R11 after clear", 11, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule